// File: doc/BRIEF.md
# Dual-Buffer Sequential Instruction Prefetcher

This block sits between an instruction fetch stage and an instruction cache and keeps two fetch buffers. Each buffer holds one aligned fetch block. For every fetch address, one buffer is chosen as the current buffer. The other buffer is always pointed at the next sequential block, so straight-line code finds its next block already requested. Misses go to the cache as load requests, each carrying a tag. A returning response clears the buffer whose outstanding tag it carries. The requester is held until the current buffer has its data.

The fetch side holds `fetch_valid` until it sees a one-cycle `fetch_ready` pulse. With that pulse, `stall_count` gives the stall cycles spent on that fetch. These are branch-penalty cycles for the first instruction of a packet, plus the cycles spent waiting for the current buffer. When `act_en` is low, the cache is off and no cycle accounting is done. In that case the block touches nothing and acknowledges the fetch straight away.

Top module: `ifetch_pingpong_prefetch`

## Requirements
- R1: Every cache request address equals a fetch address with its low bits cleared to the fetch block size. The block is 16 bytes when WIDE_FETCH=1 (the default) and 8 bytes when WIDE_FETCH=0.
- R2: A buffer whose stored address equals the aligned fetch address becomes current and is not requested again. When neither buffer matches, buffer 0 becomes current.
- R3: When the current buffer misses, it takes the aligned address and its request is issued on the next cycle after acceptance. That request comes before any prefetch request.
- R4: The non-current buffer is aimed at the aligned address plus the block size. It is requested only when it does not already hold that address.
- R5: Request tags start at 0 after reset and increase by one for every issued request.
- R6: `fetch_ready` pulses for one cycle, and only once the current buffer has no outstanding request. A buffer still in flight from an earlier prefetch is waited for and not re-requested.
- R7: A response clears only the buffer whose outstanding tag equals `crsp_tag`. A response with any other tag changes nothing.
- R8: When `fetch_first` is 1, `fetch_penalty` adds that many stall cycles ahead of the fetch wait. When `fetch_first` is 0, the penalty is ignored.
- R9: With `act_en` low, a fetch causes no request, leaves both buffers unchanged, and is acknowledged with a stall count of 0.
- R10: After reset, neither `creq_valid` nor `fetch_ready` is asserted.
- R11: `stall_count` at `fetch_ready` equals the penalty cycles plus the cycles that the current buffer stayed outstanding after the requests were issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| act_en | input | 1 | Cache enabled or cycle accounting on; low makes fetches no-ops |
| fetch_valid | input | 1 | Fetch request, held until `fetch_ready` |
| fetch_addr | input | ADDR_W | Byte address of the fetch |
| fetch_first | input | 1 | Fetch is for the first instruction of a packet |
| fetch_penalty | input | PEN_W | Pending branch penalty in cycles |
| fetch_ready | output | 1 | One-cycle pulse: current buffer is filled |
| stall_count | output | STALL_W | Stall cycles of the fetch just acknowledged |
| creq_valid | output | 1 | Cache load request |
| creq_addr | output | ADDR_W | Aligned block address of the request |
| creq_tag | output | TAG_W | Tag of the request |
| crsp_valid | input | 1 | Cache load completion |
| crsp_tag | input | TAG_W | Tag of the completed request |

## Verification
The assertions assume that the cache accepts a request in the cycle it is issued. They also assume a response never arrives in the same cycle as the request it completes, and that `fetch_valid` and its qualifiers stay stable until `fetch_ready`. The stimulus holds each fetch until the acknowledge and drops it on that cycle. Its cache model replies two or more cycles after each request, and hand-injected replies are placed only while a fetch is waiting. Latency is changed only after the reply pipeline has drained, so no reply is in flight when the tag ordering is relied on.

// File: rtl/ipf_pkg.sv
package ipf_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_PEN,
    ST_WAIT,
    ST_DONE
  } ipf_state_e;
endpackage

// File: rtl/ipf_slot.sv
module ipf_slot #(
  parameter int AW = 32,
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_addr,
  input  logic [TW-1:0] load_tag,
  input  logic          rsp_valid,
  input  logic [TW-1:0] rsp_tag,
  output logic [AW-1:0] addr,
  output logic          addr_ok,
  output logic          pend
);

  logic [TW-1:0] tag_q, tag_n;
  logic [AW-1:0] addr_n;
  logic          ok_n, pend_n, rsp_hit, upd_en;

  assign rsp_hit = rsp_valid && pend && (rsp_tag == tag_q);
  assign upd_en  = load || rsp_hit;

  always_comb begin
    addr_n = addr;
    ok_n   = addr_ok;
    tag_n  = tag_q;
    pend_n = pend;
    if (rsp_hit) pend_n = 1'b0;
    if (load) begin
      addr_n = load_addr;
      ok_n   = 1'b1;
      tag_n  = load_tag;
      pend_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr    <= '0;
      addr_ok <= 1'b0;
      tag_q   <= '0;
      pend    <= 1'b0;
    end else if (upd_en) begin
      addr    <= addr_n;
      addr_ok <= ok_n;
      tag_q   <= tag_n;
      pend    <= pend_n;
    end
  end

  AST_LOAD_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (pend && addr_ok)); // R3
  AST_STALE_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && (rsp_tag != tag_q) && !load) |=> ($stable(pend) && $stable(addr))); // R7

endmodule

// File: rtl/ipf_ctrl.sv
module ipf_ctrl
  import ipf_pkg::*;
#(
  parameter int AW          = 32,
  parameter int TW          = 8,
  parameter int PW          = 4,
  parameter int SW          = 8,
  parameter int BLOCK_BYTES = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                act_en,
  input  logic                fetch_valid,
  input  logic [AW-1:0]       fetch_addr,
  input  logic                fetch_first,
  input  logic [PW-1:0]       fetch_penalty,
  input  logic [1:0][AW-1:0]  buf_addr,
  input  logic [1:0]          buf_ok,
  input  logic [1:0]          buf_pend,
  output logic [1:0]          load,
  output logic [AW-1:0]       load_addr,
  output logic [TW-1:0]       load_tag,
  output logic                creq_valid,
  output logic                fetch_ready,
  output logic [SW-1:0]       stall_count
);

  localparam int            OFF  = $clog2(BLOCK_BYTES);
  localparam logic [AW-1:0] STEP = AW'(BLOCK_BYTES);

  ipf_state_e    st_q, st_n, after_issue;
  logic [AW-1:0] base_q, base_n, aln, pre_tgt;
  logic          cur_q, cur_n, ncur_q, ncur_n, npre_q, npre_n;
  logic [PW-1:0] pen_q, pen_n;
  logic [SW-1:0] stall_q, stall_n;
  logic [TW-1:0] tag_q, tag_n;
  logic [1:0]    hit;
  logic          sel_c, pre_hit_c, issue_cur, issue_pre, dp_en;

  assign aln     = {fetch_addr[AW-1:OFF], {OFF{1'b0}}};
  assign pre_tgt = aln + STEP;

  for (genvar i = 0; i < 2; i++) begin : g_match
    assign hit[i] = buf_ok[i] && (buf_addr[i] == aln);
  end

  assign sel_c     = hit[1] & ~hit[0];
  assign pre_hit_c = buf_ok[~sel_c] && (buf_addr[~sel_c] == pre_tgt);

  assign issue_cur   = (st_q == ST_ISSUE) && ncur_q;
  assign issue_pre   = (st_q == ST_ISSUE) && !ncur_q && npre_q;
  assign creq_valid  = issue_cur || issue_pre;
  assign load_addr   = issue_cur ? base_q : (base_q + STEP);
  assign load_tag    = tag_q;
  assign load[0]     = (issue_cur && !cur_q) || (issue_pre && cur_q);
  assign load[1]     = (issue_cur && cur_q) || (issue_pre && !cur_q);
  assign fetch_ready = (st_q == ST_DONE);
  assign stall_count = stall_q;
  assign after_issue = (pen_q != '0) ? ST_PEN : ST_WAIT;
  assign dp_en       = (st_q != ST_IDLE) || fetch_valid;

  always_comb begin
    st_n    = st_q;
    base_n  = base_q;
    cur_n   = cur_q;
    ncur_n  = ncur_q;
    npre_n  = npre_q;
    pen_n   = pen_q;
    stall_n = stall_q;
    tag_n   = tag_q;
    unique case (st_q)
      ST_IDLE: begin
        if (fetch_valid) begin
          base_n  = aln;
          cur_n   = sel_c;
          stall_n = '0;
          if (!act_en) begin
            ncur_n = 1'b0;
            npre_n = 1'b0;
            pen_n  = '0;
            st_n   = ST_DONE;
          end else begin
            ncur_n = !(hit[0] || hit[1]);
            npre_n = !pre_hit_c;
            pen_n  = fetch_first ? fetch_penalty : '0;
            if (ncur_n || npre_n) st_n = ST_ISSUE;
            else if (pen_n != '0) st_n = ST_PEN;
            else                  st_n = ST_WAIT;
          end
        end
      end
      ST_ISSUE: begin
        if (ncur_q) begin
          ncur_n = 1'b0;
          if (!npre_q) st_n = after_issue;
        end else begin
          npre_n = 1'b0;
          st_n   = after_issue;
        end
      end
      ST_PEN: begin
        stall_n = stall_q + SW'(1);
        pen_n   = pen_q - PW'(1);
        if (pen_q == PW'(1)) st_n = ST_WAIT;
      end
      ST_WAIT: begin
        if (buf_pend[cur_q]) stall_n = stall_q + SW'(1);
        else                 st_n    = ST_DONE;
      end
      ST_DONE: st_n = ST_IDLE;
      default: st_n = ST_IDLE;
    endcase
    if (creq_valid) tag_n = tag_q + TW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      base_q  <= '0;
      cur_q   <= 1'b0;
      ncur_q  <= 1'b0;
      npre_q  <= 1'b0;
      pen_q   <= '0;
      stall_q <= '0;
      tag_q   <= '0;
    end else begin
      st_q <= st_n;
      if (dp_en) begin
        base_q  <= base_n;
        cur_q   <= cur_n;
        ncur_q  <= ncur_n;
        npre_q  <= npre_n;
        pen_q   <= pen_n;
        stall_q <= stall_n;
      end
      if (creq_valid) tag_q <= tag_n;
    end
  end

  AST_REQ_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    creq_valid |-> (load_addr[OFF-1:0] == '0)); // R1
  AST_READY_FILLED: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_ready && ($past(st_q) == ST_WAIT)) |-> !buf_pend[cur_q]); // R6
  AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_ready |=> !fetch_ready); // R6
  AST_QUIET_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_IDLE) && fetch_valid && !act_en) |=> (!creq_valid && fetch_ready)); // R9

endmodule

// File: rtl/ifetch_pingpong_prefetch.sv
module ifetch_pingpong_prefetch #(
  parameter int ADDR_W     = 32,
  parameter int TAG_W      = 8,
  parameter int PEN_W      = 4,
  parameter int STALL_W    = 8,
  parameter bit WIDE_FETCH = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               act_en,
  input  logic               fetch_valid,
  input  logic [ADDR_W-1:0]  fetch_addr,
  input  logic               fetch_first,
  input  logic [PEN_W-1:0]   fetch_penalty,
  output logic               fetch_ready,
  output logic [STALL_W-1:0] stall_count,
  output logic               creq_valid,
  output logic [ADDR_W-1:0]  creq_addr,
  output logic [TAG_W-1:0]   creq_tag,
  input  logic               crsp_valid,
  input  logic [TAG_W-1:0]   crsp_tag
);

  localparam int BLOCK_BYTES = WIDE_FETCH ? 16 : 8;

  logic [1:0][ADDR_W-1:0] b_addr;
  logic [1:0]             b_ok, b_pend, b_load;
  logic [ADDR_W-1:0]      ld_addr;
  logic [TAG_W-1:0]       ld_tag;

  ipf_ctrl #(
    .AW(ADDR_W), .TW(TAG_W), .PW(PEN_W), .SW(STALL_W), .BLOCK_BYTES(BLOCK_BYTES)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .act_en(act_en),
    .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
    .fetch_first(fetch_first), .fetch_penalty(fetch_penalty),
    .buf_addr(b_addr), .buf_ok(b_ok), .buf_pend(b_pend),
    .load(b_load), .load_addr(ld_addr), .load_tag(ld_tag),
    .creq_valid(creq_valid), .fetch_ready(fetch_ready), .stall_count(stall_count)
  );

  for (genvar i = 0; i < 2; i++) begin : g_slot
    ipf_slot #(.AW(ADDR_W), .TW(TAG_W)) u_slot (
      .clk(clk), .rst_n(rst_n),
      .load(b_load[i]), .load_addr(ld_addr), .load_tag(ld_tag),
      .rsp_valid(crsp_valid), .rsp_tag(crsp_tag),
      .addr(b_addr[i]), .addr_ok(b_ok[i]), .pend(b_pend[i])
    );
  end

  assign creq_addr = ld_addr;
  assign creq_tag  = ld_tag;

endmodule

// File: tb/ifetch_pingpong_prefetch_test.sv
`timescale 1ns/1ps
module ifetch_pingpong_prefetch_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        act_en = 1'b1;
  logic        f_valid = 1'b0;
  logic [31:0] f_addr = '0;
  logic        f_first = 1'b0;
  logic [3:0]  f_pen = '0;
  logic        fetch_ready;
  logic [7:0]  stall_count;
  logic        creq_valid;
  logic [31:0] creq_addr;
  logic [7:0]  creq_tag;
  logic        crsp_valid;
  logic [7:0]  crsp_tag;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  bit          pipe_v [16];
  logic [7:0]  pipe_t [16];
  int          lat = 4;
  bit          auto_on = 1;
  bit          auto_v = 0;
  logic [7:0]  auto_t = '0;
  bit          man_v = 0;
  logic [7:0]  man_t = '0;
  logic [31:0] req_addr [64];
  logic [7:0]  req_tag [64];
  int          req_n = 0;
  int          exp_tag = 0;

  always #2.5 clk = ~clk;

  assign crsp_valid = auto_v | man_v;
  assign crsp_tag   = man_v ? man_t : auto_t;

  ifetch_pingpong_prefetch uut (
    .clk(clk), .rst_n(rst_n), .act_en(act_en),
    .fetch_valid(f_valid), .fetch_addr(f_addr),
    .fetch_first(f_first), .fetch_penalty(f_pen),
    .fetch_ready(fetch_ready), .stall_count(stall_count),
    .creq_valid(creq_valid), .creq_addr(creq_addr), .creq_tag(creq_tag),
    .crsp_valid(crsp_valid), .crsp_tag(crsp_tag)
  );

  // cache model: replies lat cycles after a request, and logs every request
  always @(negedge clk) begin
    for (int k = 15; k > 0; k--) begin
      pipe_v[k] = pipe_v[k-1];
      pipe_t[k] = pipe_t[k-1];
    end
    pipe_v[0] = creq_valid;
    pipe_t[0] = creq_tag;
    auto_v = auto_on && pipe_v[lat-1];
    auto_t = pipe_t[lat-1];
    if (creq_valid) begin
      if (req_n < 64) begin
        req_addr[req_n] = creq_addr;
        req_tag[req_n]  = creq_tag;
      end
      req_n++;
    end
  end

  task automatic chk(input string rq, input string what, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic do_fetch(input logic [31:0] a, input logic first, input logic [3:0] pen,
                          output int st, output int nq, output int base);
    bit got = 0;
    base = req_n;
    st = -1;
    @(negedge clk);
    f_valid = 1'b1; f_addr = a; f_first = first; f_pen = pen;
    for (int k = 0; k < 200 && !got; k++) begin
      @(negedge clk);
      if (fetch_ready) begin
        got = 1;
        st = int'(stall_count);
      end
    end
    f_valid = 1'b0; f_first = 1'b0; f_pen = '0;
    nq = req_n - base;
    if (!got) chk("R6", "fetch acknowledged", 0, 1);
  endtask

  task automatic chk_req(input string rq, input int idx, input logic [31:0] ea);
    chk(rq, "request address", req_addr[idx], ea);
    chk("R5", "request tag", req_tag[idx], exp_tag);
    exp_tag++;
  endtask

  task automatic t_reset;
    chk("R10", "creq_valid after reset", creq_valid, 0);
    chk("R10", "fetch_ready after reset", fetch_ready, 0);
  endtask

  task automatic t_cold;
    int st, nq, b;
    do_fetch(32'h1004, 0, 0, st, nq, b);
    chk("R3", "cold miss request count", nq, 2);
    chk_req("R1", b, 32'h1000);
    chk_req("R4", b + 1, 32'h1010);
    chk("R11", "cold miss stall", st, 2); // lat 4, two issue cycles
  endtask

  task automatic t_seq;
    int st, nq, b;
    do_fetch(32'h1018, 0, 0, st, nq, b);
    chk("R4", "sequential request count", nq, 1);
    chk_req("R4", b, 32'h1020);
    chk("R6", "sequential stall", st, 0);
    do_fetch(32'h101C, 0, 0, st, nq, b);
    chk("R2", "repeat fetch request count", nq, 0);
    chk("R6", "repeat fetch stall", st, 0);
  endtask

  task automatic t_penalty;
    int st, nq, b;
    do_fetch(32'h1010, 0, 4'd3, st, nq, b);
    chk("R8", "penalty ignored when not first", st, 0);
    do_fetch(32'h1010, 1, 4'd3, st, nq, b);
    chk("R8", "penalty on first", st, 3);
    chk("R8", "penalty fetch request count", nq, 0);
  endtask

  task automatic t_jump_priority;
    int st, nq, b;
    do_fetch(32'h2000, 0, 0, st, nq, b);
    chk("R3", "jump request count", nq, 2);
    chk_req("R3", b, 32'h2000);
    chk_req("R4", b + 1, 32'h2010);
    do_fetch(32'h2010, 0, 0, st, nq, b);
    chk_req("R4", b, 32'h2020);
    do_fetch(32'h2020, 0, 0, st, nq, b);
    chk_req("R4", b, 32'h2030);
    // buffers now 0x2020 / 0x2030; 0x2010 matches neither -> buffer 0 current,
    // so the other buffer (0x2030) must be retargeted to 0x2020
    do_fetch(32'h2014, 0, 0, st, nq, b);
    chk("R2", "priority buffer request count", nq, 2);
    chk_req("R2", b, 32'h2010);
    chk_req("R2", b + 1, 32'h2020);
    chk("R11", "priority miss stall", st, 2);
  endtask

  task automatic t_disabled;
    int st, nq, b;
    act_en = 1'b0;
    do_fetch(32'h4000, 1, 4'd5, st, nq, b);
    chk("R9", "disabled request count", nq, 0);
    chk("R9", "disabled stall", st, 0);
    act_en = 1'b1;
    do_fetch(32'h2010, 0, 0, st, nq, b);
    chk("R9", "buffers kept while disabled", nq, 0);
    chk("R9", "stall after disabled fetch", st, 0);
  endtask

  task automatic t_inflight;
    int st, nq, b;
    repeat (12) @(negedge clk);
    lat = 10;
    do_fetch(32'h5000, 0, 0, st, nq, b);
    chk("R11", "long latency miss stall", st, 8); // lat-2
    exp_tag += 2;
    do_fetch(32'h5010, 0, 0, st, nq, b);
    exp_tag += nq;
    chk("R6", "hit on filled prefetch stall", st, 0);
    // 0x5020 was requested one cycle into the previous fetch; still in flight
    do_fetch(32'h5020, 0, 0, st, nq, b);
    chk("R6", "in-flight block not re-requested", nq, 1);
    chk_req("R4", b, 32'h5030);
    chk("R11", "wait on in-flight prefetch", st, 5);
    repeat (12) @(negedge clk);
    lat = 4;
  endtask

  task automatic t_stale;
    int b;
    bit early = 0;
    bit got = 0;
    logic [7:0] ct, pt;
    repeat (8) @(negedge clk);
    auto_on = 0;
    b = req_n;
    @(negedge clk);
    f_valid = 1'b1; f_addr = 32'h6008; f_first = 1'b0; f_pen = '0;
    repeat (6) begin @(negedge clk); if (fetch_ready) early = 1; end
    chk("R3", "stale test request count", req_n - b, 2);
    ct = req_tag[b];
    pt = req_tag[b + 1];
    man_t = ct + 8'd8; man_v = 1;
    @(negedge clk); if (fetch_ready) early = 1; man_v = 0;
    repeat (5) begin @(negedge clk); if (fetch_ready) early = 1; end
    chk("R7", "unmatched tag ignored", early, 0);
    man_t = pt; man_v = 1;
    @(negedge clk); if (fetch_ready) early = 1; man_v = 0;
    repeat (5) begin @(negedge clk); if (fetch_ready) early = 1; end
    chk("R7", "prefetch tag leaves current pending", early, 0);
    man_t = ct; man_v = 1;
    @(negedge clk); man_v = 0;
    for (int k = 0; k < 10 && !got; k++) begin
      @(negedge clk);
      if (fetch_ready) got = 1;
    end
    f_valid = 1'b0;
    chk("R6", "ready after current tag returns", got, 1);
    auto_on = 1;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_cold;
    t_seq;
    t_penalty;
    t_jump_priority;
    t_disabled;
    t_inflight;
    t_stale;
    repeat (4) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule